// File: doc/BRIEF.md
# One-Source Integer Data-Processing Unit

This unit handles the single-operand integer instruction class. It takes a 32-bit instruction word and a 64-bit source value. If the word belongs to the class, the unit produces the destination value one clock later. The operations are:

- reversing the bit order;
- reversing bytes inside each 16-bit lane, each 32-bit lane, or across the whole 64-bit value;
- counting leading zero bits;
- counting leading copies of the sign bit.

A width-select bit in the instruction picks the operand size. A 64-bit operation uses the whole operand. A 32-bit operation sees only the low word, and its result is zero-extended into the 64-bit destination.

The unit checks the encoding strictly before it writes anything. Some words carry the class pattern but use a reserved field or an unassigned operation code. For those, the unit raises an undefined flag instead of a write strobe. Words outside the class pattern produce no output at all.

The source register index is decoded combinationally, so an external register file can supply the operand in the same cycle. The destination index travels with the registered result.

Top module: `one_src_dp_unit`

## Requirements
- R1: A word is claimed only when bit 30 is 1 and bits 28..21 equal 8'b11010110. An unclaimed word with in_valid high leaves out_valid and undef low in the following cycle, and result and rd_index keep their previous values.
- R2: A claimed word with bit 29 (S) set, or with a nonzero field in bits 20..16, pulses undef for one cycle. In that cycle out_valid stays low and result is all zeros.
- R3: A claimed word whose operation code (bits 15..10) is 6 to 63 is undefined and behaves as in R2. So is operation code 3 with the width bit (bit 31) equal to 0.
- R4: For a claimed word accepted on a clock edge where in_valid is high, out_valid or undef is high during the next cycle only. rd_index then equals bits 4..0 of that word.
- R5: rn_index equals bits 9..5 of insn in the same cycle, without a register.
- R6: Operation code 0 gives the bit-reversed operand: result bit i equals operand bit W-1-i, where W is 64 or 32.
- R7: Operation code 1 swaps the two bytes of every 16-bit lane.
- R8: Operation code 2 reverses the four bytes of every 32-bit lane.
- R9: Operation code 3 with bit 31 equal to 1 reverses all eight bytes of the 64-bit operand.
- R10: Operation code 4 gives the count of leading zero bits. An all-zero operand gives W, that is 64 or 32.
- R11: Operation code 5 gives the number of consecutive bits below the top bit that equal the top bit. An all-zero or all-ones operand gives W-1.
- R12: With bit 31 equal to 0, only operand bits 31..0 affect the result, and result bits 63..32 are zero.
- R13: While reset (rst_n low) is applied, out_valid, undef, rd_index and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The instruction word and operand are valid this cycle |
| insn | input | 32 | Instruction word |
| rn_value | input | 64 | Source operand value |
| rn_index | output | 5 | Source register index, decoded combinationally |
| out_valid | output | 1 | One-cycle write strobe for result |
| rd_index | output | 5 | Registered destination register index |
| result | output | 64 | Registered destination value |
| undef | output | 1 | One-cycle flag for an undefined encoding |

## Verification
The bench targets the edges of the counts.

- A zero operand must give the full width for the zero count and one less than the width for the sign count. An off-by-one loop bound would return 63 or 65.
- In 32-bit mode the upper operand word is filled with garbage. A datapath that ignored the width bit would leak those bits into the count or into the reversed value.
- The reserved-field cases are checked against out_valid. This catches a decoder that forgets the S bit or the second opcode field and would write a result.
- 32-bit full reversal must be rejected.
- Words outside the class must leave the held result untouched.

// File: rtl/odp_pkg.sv
package odp_pkg;

  typedef enum logic [2:0] {
    OP_RBIT  = 3'd0,
    OP_REV16 = 3'd1,
    OP_REV32 = 3'd2,
    OP_REV64 = 3'd3,
    OP_CLZ   = 3'd4,
    OP_CLS   = 3'd5
  } opKind_e;

  // strobes from decode control into the datapath
  typedef struct packed {
    logic    load;   // legal word accepted: capture computed value
    logic    clear;  // undefined word accepted: zero the result
    logic    wide;   // 64-bit operation
    opKind_e op;
  } dpStrobe_t;

endpackage

// File: rtl/odp_ctrl.sv
module odp_ctrl
  import odp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [31:0] insn,
  output dpStrobe_t   strobe,
  output logic [4:0]  rnIndex,
  output logic [4:0]  rdIndex,
  output logic        outValid,
  output logic        undefFlag
);
  localparam logic [7:0] CLASS_PAT = 8'b11010110;
  localparam logic [5:0] LAST_OP   = 6'd5;

  logic       claimed;
  logic       illegal;
  logic       fire;
  logic [5:0] opField;

  assign opField = insn[15:10];
  assign claimed = insn[30] && (insn[28:21] == CLASS_PAT);
  assign illegal = insn[29] || (insn[20:16] != 5'd0) || (opField > LAST_OP)
                || ((opField == 6'd3) && !insn[31]);
  assign fire    = inValid && claimed;
  assign rnIndex = insn[9:5];

  always_comb begin
    strobe.load  = fire && !illegal;
    strobe.clear = fire && illegal;
    strobe.wide  = insn[31];
    strobe.op    = opKind_e'(opField[2:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      undefFlag <= 1'b0;
      rdIndex   <= '0;
    end else begin
      outValid  <= strobe.load;
      undefFlag <= strobe.clear;
      if (fire) rdIndex <= insn[4:0];
    end
  end
endmodule

// File: rtl/odp_datapath.sv
module odp_datapath
  import odp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dpStrobe_t       strobe,
  input  logic [XLEN-1:0] rnValue,
  output logic [XLEN-1:0] result
);
  localparam int HALF  = XLEN / 2;
  localparam int BYTES = XLEN / 8;
  localparam int CNT_W = $clog2(XLEN) + 1;

  logic [XLEN-1:0] rbitFull, rev16, rev32, rev64, lowMask, nextVal;
  logic [HALF-1:0] rbitLow;
  logic [CNT_W-1:0] clzCnt, clsCnt;
  logic zStop, sStop, topBit;

  // bit reversal networks, full width and low word
  for (genvar g = 0; g < XLEN; g++) begin : g_rbit
    assign rbitFull[g] = rnValue[XLEN-1-g];
    if (g < HALF) begin : g_low
      assign rbitLow[g] = rnValue[HALF-1-g];
    end
  end

  // byte permutations: lane-local swaps are index XORs
  for (genvar b = 0; b < BYTES; b++) begin : g_bytes
    assign rev16[b*8 +: 8] = rnValue[(b ^ 1)*8 +: 8];
    assign rev32[b*8 +: 8] = rnValue[(b ^ 3)*8 +: 8];
    assign rev64[b*8 +: 8] = rnValue[(b ^ (BYTES-1))*8 +: 8];
  end

  assign lowMask = strobe.wide ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign topBit  = strobe.wide ? rnValue[XLEN-1] : rnValue[HALF-1];

  always_comb begin
    clzCnt = '0;
    zStop  = 1'b0;
    for (int i = XLEN-1; i >= 0; i--) begin
      if ((strobe.wide || i < HALF) && !zStop) begin
        if (rnValue[i]) zStop = 1'b1;
        else            clzCnt = clzCnt + 1'b1;
      end
    end
  end

  always_comb begin
    clsCnt = '0;
    sStop  = 1'b0;
    for (int i = XLEN-2; i >= 0; i--) begin
      if ((strobe.wide || i < HALF-1) && !sStop) begin
        if (rnValue[i] == topBit) clsCnt = clsCnt + 1'b1;
        else                      sStop  = 1'b1;
      end
    end
  end

  always_comb begin
    case (strobe.op)
      OP_RBIT:  nextVal = strobe.wide ? rbitFull : {{HALF{1'b0}}, rbitLow};
      OP_REV16: nextVal = rev16 & lowMask;
      OP_REV32: nextVal = rev32 & lowMask;
      OP_REV64: nextVal = rev64;
      OP_CLZ:   nextVal = {{(XLEN-CNT_W){1'b0}}, clzCnt};
      OP_CLS:   nextVal = {{(XLEN-CNT_W){1'b0}}, clsCnt};
      default:  nextVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            result <= '0;
    else if (strobe.load)  result <= nextVal;
    else if (strobe.clear) result <= '0;
  end
endmodule

// File: rtl/one_src_dp_unit.sv
module one_src_dp_unit
  import odp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] rn_value,
  output logic [4:0]      rn_index,
  output logic            out_valid,
  output logic [4:0]      rd_index,
  output logic [XLEN-1:0] result,
  output logic            undef
);
  dpStrobe_t strobe;

  odp_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(in_valid), .insn(insn),
    .strobe(strobe), .rnIndex(rn_index), .rdIndex(rd_index),
    .outValid(out_valid), .undefFlag(undef)
  );

  odp_datapath #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rnValue(rn_value), .result(result)
  );
endmodule

// File: rtl/one_src_dp_checks.sv
module one_src_dp_checks #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     insn,
  input logic            out_valid,
  input logic            undef,
  input logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;

  logic isClass;
  assign isClass = insn[30] && (insn[28:21] == 8'b11010110);

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && undef));

  assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (result == '0));

  assert_sbit_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && isClass && insn[29]) |=> undef);

  assert_unclaimed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !isClass) |=> (!out_valid && !undef));

  assert_narrow_rev64_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && isClass && !insn[31] && insn[15:10] == 6'd3) |=> undef);

  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insn[31]) |=> (!(out_valid || undef) || result[XLEN-1:HALF] == '0));

  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_clz_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(insn[15:10]) == 6'd4) |-> (result <= XLEN));
endmodule

bind one_src_dp_unit one_src_dp_checks #(.XLEN(XLEN)) checks_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
  .out_valid(out_valid), .undef(undef), .result(result)
);

// File: tb/one_src_dp_unit_tb_top.sv
`timescale 1ns/1ps
module one_src_dp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn;
  logic [63:0] rn_value;
  logic [4:0]  rn_index, rd_index;
  logic        out_valid, undef;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  logic        expValid = 1'b0, expUndef = 1'b0;
  logic [4:0]  expRd = '0;
  logic [63:0] expResult = '0;

  always #2.5 clk = ~clk;

  one_src_dp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rn_value(rn_value), .rn_index(rn_index), .out_valid(out_valid),
    .rd_index(rd_index), .result(result), .undef(undef)
  );

  function automatic logic [31:0] mk(bit sf, bit s, logic [4:0] op2,
                                     logic [5:0] opc, logic [4:0] rn, logic [4:0] rd);
    return {sf, 1'b1, s, 8'b11010110, op2, opc, rn, rd};
  endfunction

  // behavioural reference: byte list permutation, shifting counters
  function automatic logic [63:0] refOp(bit wide, int opc, logic [63:0] x);
    int w = wide ? 64 : 32;
    logic [63:0] v = wide ? x : {32'h0, x[31:0]};
    logic [63:0] r = '0;
    int n = 0;
    int m = 0;
    case (opc)
      0: for (int i = 0; i < w; i++) r[i] = v[w-1-i];
      1, 2, 3: begin
        m = (opc == 1) ? 1 : (opc == 2) ? 3 : 7;
        for (int j = 0; j < w/8; j++) r[j*8 +: 8] = v[(j ^ m)*8 +: 8];
      end
      4: begin
        while (n < w && v[w-1-n] == 1'b0) n++;
        r = 64'(n);
      end
      5: begin
        while (n < w-1 && v[w-2-n] == v[w-1]) n++;
        r = 64'(n);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] w, logic [63:0] x, string tag);
    bit claimed, bad;
    @(negedge clk);
    in_valid = v; insn = w; rn_value = x;
    #1;
    chk("R5", "rn_index", 64'(rn_index), 64'(w[9:5]));
    claimed = v && w[30] && (w[28:21] == 8'hD6);
    bad = w[29] || (w[20:16] != 0) || (w[15:10] > 5) || (w[15:10] == 3 && !w[31]);
    if (claimed) begin
      expValid = !bad; expUndef = bad; expRd = w[4:0];
      expResult = bad ? 64'h0 : refOp(w[31], int'(w[15:10]), x);
    end else begin
      expValid = 1'b0; expUndef = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(tag, "out_valid", 64'(out_valid), 64'(expValid));
    chk(tag, "undef", 64'(undef), 64'(expUndef));
    chk(tag, "rd_index", 64'(rd_index), 64'(expRd));
    chk(tag, "result", result, expResult);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; rn_value = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13", "out_valid", 64'(out_valid), 0);
    chk("R13", "undef", 64'(undef), 0);
    chk("R13", "rd_index", 64'(rd_index), 0);
    chk("R13", "result", result, 0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 32'h0, 64'h0, "R4");
    // R6 bit reverse
    step(1, mk(1,0,0,0,5'd3,5'd7), 64'h0123_4567_89AB_CDEF, "R6");
    step(1, mk(0,0,0,0,5'd4,5'd8), 64'hFFFF_0000_0000_0001, "R6");
    // R7 / R8 / R9 byte reversals
    step(1, mk(1,0,0,1,5'd1,5'd2), 64'h0011_2233_4455_6677, "R7");
    step(1, mk(0,0,0,1,5'd1,5'd2), 64'hDEAD_BEEF_1122_3344, "R7");
    step(1, mk(1,0,0,2,5'd9,5'd10), 64'h0011_2233_4455_6677, "R8");
    step(1, mk(0,0,0,2,5'd9,5'd10), 64'hDEAD_BEEF_1122_3344, "R8");
    step(1, mk(1,0,0,3,5'd31,5'd30), 64'h0011_2233_4455_6677, "R9");
    // R10 leading zeros
    step(1, mk(1,0,0,4,5'd0,5'd1), 64'h0, "R10");
    step(1, mk(0,0,0,4,5'd0,5'd1), 64'hFFFF_FFFF_0000_0000, "R10");
    step(1, mk(1,0,0,4,5'd0,5'd1), 64'h1, "R10");
    step(1, mk(1,0,0,4,5'd0,5'd1), 64'h8000_0000_0000_0000, "R10");
    step(1, mk(0,0,0,4,5'd0,5'd1), 64'h1234_5678_0000_8000, "R12");
    // R11 leading sign bits
    step(1, mk(1,0,0,5,5'd2,5'd3), 64'h0, "R11");
    step(1, mk(1,0,0,5,5'd2,5'd3), 64'hFFFF_FFFF_FFFF_FFFF, "R11");
    step(1, mk(0,0,0,5,5'd2,5'd3), 64'h0000_0000_FFFF_FFFF, "R11");
    step(1, mk(0,0,0,5,5'd2,5'd3), 64'hFFFF_FFFF_0000_0000, "R11");
    step(1, mk(0,0,0,5,5'd2,5'd3), 64'h0000_0000_8000_0000, "R11");
    step(1, mk(1,0,0,5,5'd2,5'd3), 64'hC000_0000_0000_0000, "R11");
    step(0, 32'h0, 64'h0, "R4");
    // R2 reserved fields
    step(1, mk(1,1,0,4,5'd1,5'd6), 64'h1, "R2");
    step(1, mk(1,0,5'd1,0,5'd1,5'd11), 64'h1, "R2");
    step(1, mk(0,0,5'd16,4,5'd1,5'd12), 64'h1, "R2");
    // R3 unassigned codes
    step(1, mk(1,0,0,4,5'd1,5'd13), 64'h5, "R3");
    step(1, mk(1,0,0,6'd6,5'd1,5'd14), 64'h5, "R3");
    step(1, mk(1,0,0,6'd63,5'd1,5'd15), 64'h5, "R3");
    step(1, mk(0,0,0,3,5'd1,5'd16), 64'h5, "R3");
    // R1 unclaimed words keep held result
    step(1, mk(1,0,0,4,5'd1,5'd17), 64'h00FF, "R1");
    step(1, mk(1,0,0,4,5'd1,5'd18) & ~32'h4000_0000, 64'h0, "R1");
    step(1, mk(1,0,0,4,5'd1,5'd19) ^ 32'h0020_0000, 64'h0, "R1");
    step(1, 32'hFFFF_FFFF, 64'h0, "R1");
    // R4 back-to-back and valid-low idle
    step(1, mk(1,0,0,0,5'd1,5'd20), 64'hA5, "R4");
    step(1, mk(1,0,0,0,5'd1,5'd21), 64'h5A, "R4");
    step(0, mk(1,0,0,0,5'd1,5'd22), 64'h5A, "R4");

    for (int k = 0; k < 300; k++) begin
      logic [63:0] x;
      int opc;
      bit sf;
      opc = int'($urandom % 6);
      sf = 1'($urandom);
      if (opc == 3) sf = 1'b1;
      x = {$urandom, $urandom};
      if (k % 7 == 0) x = x >> ($urandom % 64);
      if (k % 11 == 0) x = ~(x >> ($urandom % 64));
      step(($urandom % 5) != 0, mk(sf, 0, 0, 6'(opc), 5'($urandom), 5'($urandom)), x,
           sf ? "R6" : "R12");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule